// File: doc/BRIEF.md
# IDE PIO Single-Sector Command Sequencer

This block takes single-sector transfer requests and carries each one out on an 8-bit legacy disk register bus, with no help from software. A request names the direction, a 28-bit logical block address and the drive (master or slave). The sequencer polls status until the drive can take a command. It then programs the control register and the task-file registers in a fixed order and writes the command opcode. After that it moves one 512-byte sector as 128 32-bit words between the data port and a word-addressed sector buffer. It then checks final status and, when the drive flags an error, fetches the error register and returns its code.

Requests are accepted on a valid/ready handshake into a four-entry queue. When one request completes, the next queued request starts. Every completion gives a one-cycle pulse with an error flag, a timeout flag and the 8-bit error code. Each status poll has a cycle budget set on an input. If the awaited condition is still absent after that many consecutive status reads, the request ends with the timeout flag set.

Top module: `ata_pio_seq`

## Requirements
- R1: Out of reset, req_ready is 1, io_rd, io_wr and done are 0, and no bus write takes place until a request is accepted.
- R2: Before any register write for a request, status (address 0x1F7) is read repeatedly until bit 7 (busy) is 0 and bit 6 (ready) is 1; the first write follows the first such read.
- R3: The setup writes go in this order: 0x00 to control (0x3F6), 0x01 to sector count (0x1F2), then LBA bits 7:0, 15:8 and 23:16 to 0x1F3, 0x1F4 and 0x1F5.
- R4: The next write is to 0x1F6 with the value 0xE0 OR (drive << 4) OR LBA bits 27:24, where drive 1 selects the slave.
- R5: The next write is the opcode to 0x1F7: 0x30 for a write request, 0x20 for a read request.
- R6: For a write, status is polled until busy is 0, ready is 1 and bit 3 (data request) is 1. Then 128 writes go to the data port 0x1F0, carrying buffer words 0 to 127 in order, and the block waits for drive_irq before it polls final status.
- R7: For a read, the block waits for drive_irq, polls until ready with data request, then reads 0x1F0 128 times and stores the words at buffer addresses 0 to 127 in order.
- R8: If a status read that ends a poll shows bit 0 (error), address 0x1F1 is read. The completion then carries done_err=1 and done_code equal to that register's low byte. Otherwise done_err=0 and done_code=0.
- R9: Up to four requests wait in a queue behind the active one. req_ready is 0 while the queue is full, and queued requests are carried out in arrival order.
- R10: When a poll reads status timeout_limit consecutive times without the awaited condition, the request ends with done_timeout=1 and no further bus writes.
- R11: io_rd and io_wr are never high together, and done is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timeout_limit | input | 16 | Consecutive unmet status reads allowed per poll (at least 1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_write | input | 1 | 1 = write sector to disk, 0 = read |
| req_drive | input | 1 | 0 = master, 1 = slave |
| req_lba | input | 28 | Logical block address |
| buf_addr | output | 7 | Sector buffer word index |
| buf_rdata | input | 32 | Buffer word at buf_addr (combinational) |
| buf_we | output | 1 | Store buf_wdata at buf_addr |
| buf_wdata | output | 32 | Word read from the drive |
| io_addr | output | 10 | Register bus address |
| io_rd | output | 1 | Register read strobe; io_rdata sampled this cycle |
| io_wr | output | 1 | Register write strobe |
| io_wdata | output | 32 | Write data (low byte for 8-bit registers) |
| io_rdata | input | 32 | Read data returned in the same cycle |
| drive_irq | input | 1 | Drive interrupt |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Drive reported an error |
| done_timeout | output | 1 | A poll ran out of budget |
| done_code | output | 8 | Error register value, 0 when no error |

## Verification
The hardest situation to reach is a queue held full while a request is still in flight. The bench gets there by pushing one request and letting it start. It then pushes four more back to back and samples req_ready before the drive model finishes the first transfer, and afterwards it compares the order of the LBA bytes the drive saw. Error paths are reached by a drive model that raises the error bit at different points: before the data phase on reads, and at final status on writes. Timeouts come from loading more busy reads than the poll budget allows.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int LBA_W = 28;

  localparam logic [9:0] A_DATA = 10'h1F0;
  localparam logic [9:0] A_ERR  = 10'h1F1;
  localparam logic [9:0] A_CNT  = 10'h1F2;
  localparam logic [9:0] A_L0   = 10'h1F3;
  localparam logic [9:0] A_L1   = 10'h1F4;
  localparam logic [9:0] A_L2   = 10'h1F5;
  localparam logic [9:0] A_DEV  = 10'h1F6;
  localparam logic [9:0] A_STAT = 10'h1F7;
  localparam logic [9:0] A_CTL  = 10'h3F6;

  localparam int ST_BSY = 7;
  localparam int ST_RDY = 6;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  localparam logic [7:0] OP_RD    = 8'h20;
  localparam logic [7:0] OP_WR    = 8'h30;
  localparam logic [7:0] DEV_BASE = 8'hE0;

  typedef struct packed {
    logic             wr;
    logic             drv;
    logic [LBA_W-1:0] lba;
  } req_t;

  typedef enum logic [4:0] {
    S_IDLE, S_POLL_RDY, S_CTL, S_CNT, S_L0, S_L1, S_L2, S_DEV, S_CMD,
    S_POLL_XFER, S_WDATA, S_WIRQ, S_RIRQ, S_RDATA, S_POLL_END, S_ERRRD, S_DONE
  } st_t;
endpackage

// File: rtl/seq_req_fifo.sv
module seq_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic [W-1:0] out_data,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign in_ready = (cnt_q != CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_push  = push && in_ready;
  assign do_pop   = pop && !empty;
  assign out_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= in_data;
  end

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == limit - 1'b1);

  always_comb begin
    if (!run || expired) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_seq_pkg::*;
#(
  parameter int WORDS      = 128,
  parameter int QDEPTH     = 4,
  parameter int TMR_W      = 16,
  parameter int DW         = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TMR_W-1:0]         timeout_limit,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_drive,
  input  logic [LBA_W-1:0]         req_lba,
  output logic [$clog2(WORDS)-1:0] buf_addr,
  input  logic [DW-1:0]            buf_rdata,
  output logic                     buf_we,
  output logic [DW-1:0]            buf_wdata,
  output logic [9:0]               io_addr,
  output logic                     io_rd,
  output logic                     io_wr,
  output logic [DW-1:0]            io_wdata,
  input  logic [DW-1:0]            io_rdata,
  input  logic                     drive_irq,
  output logic                     done,
  output logic                     done_err,
  output logic                     done_timeout,
  output logic [7:0]               done_code
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int RQ_W  = $bits(req_t);

  st_t              st_q, st_d;
  req_t             cur_q, cur_d, q_out;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d, to_q, to_d;
  logic [7:0]       code_q, code_d;
  logic             q_empty, q_pop;
  logic             rdy_ok, xfer_ok, met, polling, tmr_run, tmr_exp, last_word;

  seq_req_fifo #(.DEPTH(QDEPTH), .W(RQ_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (req_valid),
    .in_data  ({req_write, req_drive, req_lba}),
    .in_ready (req_ready),
    .pop      (q_pop),
    .out_data (q_out),
    .empty    (q_empty)
  );

  seq_poll_timer #(.W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .limit   (timeout_limit),
    .expired (tmr_exp)
  );

  assign rdy_ok    = !io_rdata[ST_BSY] && io_rdata[ST_RDY];
  assign xfer_ok   = rdy_ok && (io_rdata[ST_DRQ] || io_rdata[ST_ERR]);
  assign polling   = (st_q == S_POLL_RDY) || (st_q == S_POLL_XFER) || (st_q == S_POLL_END);
  assign met       = (st_q == S_POLL_XFER) ? xfer_ok : rdy_ok;
  assign tmr_run   = polling && !met;
  assign last_word = (idx_q == IDX_W'(WORDS - 1));

  // bus strobes, address and data follow the state
  always_comb begin
    io_rd     = 1'b0;
    io_wr     = 1'b0;
    io_addr   = A_STAT;
    io_wdata  = '0;
    buf_we    = 1'b0;
    buf_addr  = idx_q;
    buf_wdata = io_rdata;
    case (st_q)
      S_POLL_RDY, S_POLL_XFER, S_POLL_END: io_rd = 1'b1;
      S_CTL:   begin io_wr = 1'b1; io_addr = A_CTL; end
      S_CNT:   begin io_wr = 1'b1; io_addr = A_CNT; io_wdata = DW'(8'h01); end
      S_L0:    begin io_wr = 1'b1; io_addr = A_L0; io_wdata = DW'(cur_q.lba[7:0]); end
      S_L1:    begin io_wr = 1'b1; io_addr = A_L1; io_wdata = DW'(cur_q.lba[15:8]); end
      S_L2:    begin io_wr = 1'b1; io_addr = A_L2; io_wdata = DW'(cur_q.lba[23:16]); end
      S_DEV:   begin
        io_wr = 1'b1; io_addr = A_DEV;
        io_wdata = DW'(DEV_BASE | {3'b000, cur_q.drv, cur_q.lba[27:24]});
      end
      S_CMD:   begin io_wr = 1'b1; io_addr = A_STAT; io_wdata = DW'(cur_q.wr ? OP_WR : OP_RD); end
      S_WDATA: begin io_wr = 1'b1; io_addr = A_DATA; io_wdata = buf_rdata; end
      S_RDATA: begin io_rd = 1'b1; io_addr = A_DATA; buf_we = 1'b1; end
      S_ERRRD: begin io_rd = 1'b1; io_addr = A_ERR; end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    idx_d  = idx_q;
    err_d  = err_q;
    to_d   = to_q;
    code_d = code_q;
    q_pop  = 1'b0;
    case (st_q)
      S_IDLE, S_DONE: begin
        st_d = S_IDLE;
        if (!q_empty) begin
          q_pop  = 1'b1;
          cur_d  = q_out;
          err_d  = 1'b0;
          to_d   = 1'b0;
          code_d = '0;
          idx_d  = '0;
          st_d   = S_POLL_RDY;
        end
      end
      S_POLL_RDY: begin
        if (met)          st_d = S_CTL;
        else if (tmr_exp) begin to_d = 1'b1; st_d = S_DONE; end
      end
      S_CTL:   st_d = S_CNT;
      S_CNT:   st_d = S_L0;
      S_L0:    st_d = S_L1;
      S_L1:    st_d = S_L2;
      S_L2:    st_d = S_DEV;
      S_DEV:   st_d = S_CMD;
      S_CMD:   st_d = cur_q.wr ? S_POLL_XFER : S_RIRQ;
      S_RIRQ:  if (drive_irq) st_d = S_POLL_XFER;
      S_POLL_XFER: begin
        if (met) begin
          if (io_rdata[ST_ERR]) st_d = S_ERRRD;
          else                  st_d = cur_q.wr ? S_WDATA : S_RDATA;
        end else if (tmr_exp) begin
          to_d = 1'b1; st_d = S_DONE;
        end
      end
      S_WDATA: begin
        idx_d = idx_q + 1'b1;
        if (last_word) st_d = S_WIRQ;
      end
      S_RDATA: begin
        idx_d = idx_q + 1'b1;
        if (last_word) st_d = S_POLL_END;
      end
      S_WIRQ:  if (drive_irq) st_d = S_POLL_END;
      S_POLL_END: begin
        if (met)          st_d = io_rdata[ST_ERR] ? S_ERRRD : S_DONE;
        else if (tmr_exp) begin to_d = 1'b1; st_d = S_DONE; end
      end
      S_ERRRD: begin
        err_d  = 1'b1;
        code_d = io_rdata[7:0];
        st_d   = S_DONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
      to_q   <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      to_q   <= to_d;
      code_q <= code_d;
    end
  end

  assign done         = (st_q == S_DONE);
  assign done_err     = err_q;
  assign done_timeout = to_q;
  assign done_code    = code_q;

  // R11
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_rd, io_wr}));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  ctl_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_CTL) |->
      $past(io_rd && io_addr == A_STAT && !io_rdata[ST_BSY] && io_rdata[ST_RDY]));

  // R5
  cmd_after_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_STAT) |-> $past(io_wr && io_addr == A_DEV));

  // R8
  clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_code == 8'h00));

  // R6
  data_after_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_DATA && !$past(io_wr && io_addr == A_DATA)) |->
      $past(io_rd && io_addr == A_STAT && io_rdata[ST_DRQ]));
endmodule

// File: tb/ata_pio_seq_tb.sv
module ata_pio_seq_tb;
  logic        clk, rst_n;
  logic [15:0] tmo;
  logic        req_valid, req_ready, req_write, req_drive;
  logic [27:0] req_lba;
  logic [6:0]  buf_addr;
  logic [31:0] buf_rdata, buf_wdata, io_wdata, io_rdata;
  logic        buf_we, io_rd, io_wr, drive_irq;
  logic [9:0]  io_addr;
  logic        done, done_err, done_timeout;
  logic [7:0]  done_code;

  ata_pio_seq u_dut (
    .clk(clk), .rst_n(rst_n), .timeout_limit(tmo),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_drive(req_drive), .req_lba(req_lba),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .drive_irq(drive_irq), .done(done), .done_err(done_err),
    .done_timeout(done_timeout), .done_code(done_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit wd_hit = 0;

  // drive model configuration (driven only by initial block)
  int          cfg_pre, cfg_mid;
  bit          cfg_inj, load, clr;
  logic [7:0]  cfg_code;
  logic [27:0] cfg_lba;
  logic [31:0] wbuf [128];
  logic [31:0] rbuf [128];

  // drive model state (driven only by the model process)
  int         busy_left, irq_cnt, rptr, wptr, nlog, pre_reads, nwe, qn;
  bit         drq, err, ctl_seen, irq_q;
  logic [9:0]  log_a [160];
  logic [31:0] log_d [160];
  logic [7:0]  qlba [8];

  assign drive_irq = irq_q;
  assign buf_rdata = wbuf[buf_addr];

  function automatic logic [31:0] rdw(logic [27:0] l, int k);
    return {l[15:0] ^ 16'h3C3C, 8'(k), 8'(255 - k)};
  endfunction

  always_comb begin
    logic bsy;
    bsy = (busy_left > 0);
    case (io_addr)
      10'h1F7: io_rdata = {24'h0, bsy, 1'b1, 2'b00, drq && !bsy, 2'b00, err && !bsy};
      10'h1F1: io_rdata = {24'h0, cfg_code};
      10'h1F0: io_rdata = rdw(cfg_lba, rptr);
      default: io_rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_we) begin rbuf[buf_addr] <= buf_wdata; nwe <= nwe + 1; end
    if (irq_cnt > 0) begin
      irq_cnt <= irq_cnt - 1;
      if (irq_cnt == 1) irq_q <= 1'b1;
    end
    if (io_rd && io_addr == 10'h1F7) begin
      if (busy_left > 0) busy_left <= busy_left - 1;
      if (!ctl_seen) pre_reads <= pre_reads + 1;
      irq_q <= 1'b0;
    end
    if (io_rd && io_addr == 10'h1F0) begin
      rptr <= rptr + 1;
      if (rptr == 127) drq <= 1'b0;
    end
    if (io_wr) begin
      if (nlog < 160) begin log_a[nlog] <= io_addr; log_d[nlog] <= io_wdata; end
      nlog <= nlog + 1;
      if (io_addr == 10'h3F6) ctl_seen <= 1'b1;
      if (io_addr == 10'h1F3) begin qlba[qn[2:0]] <= io_wdata[7:0]; qn <= qn + 1; end
      if (io_addr == 10'h1F7) begin
        busy_left <= cfg_mid; rptr <= 0; wptr <= 0;
        if (io_wdata[7:0] == 8'h20) begin
          drq <= !cfg_inj; err <= cfg_inj; irq_cnt <= 3;
        end else begin
          drq <= 1'b1; err <= 1'b0;
        end
      end
      if (io_addr == 10'h1F0) begin
        wptr <= wptr + 1;
        if (wptr == 127) begin
          drq <= 1'b0; busy_left <= cfg_mid; irq_cnt <= 3; err <= cfg_inj;
        end
      end
    end
    if (load) begin
      busy_left <= cfg_pre; drq <= 1'b0; err <= 1'b0; irq_q <= 1'b0; irq_cnt <= 0;
      ctl_seen <= 1'b0; pre_reads <= 0;
    end
    if (clr) begin nlog <= 0; nwe <= 0; qn <= 0; end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done && !wd_hit) @(negedge clk);
  endtask

  task automatic run_req(bit wr, bit drv, logic [27:0] lba, int pre, int mid,
                         bit inj, logic [7:0] code, bit exp_to);
    @(negedge clk);
    cfg_pre = pre; cfg_mid = mid; cfg_inj = inj; cfg_code = code; cfg_lba = lba;
    for (int k = 0; k < 128; k++) wbuf[k] = {lba[15:0], 8'(k), 8'(3 * k)} ^ 32'h5A000000;
    load = 1; clr = 1;
    @(negedge clk);
    load = 0; clr = 0;
    req_valid = 1; req_write = wr; req_drive = drv; req_lba = lba;
    @(negedge clk);
    req_valid = 0;
    wait_done();
    if (exp_to) begin
      chk(done_timeout == 1'b1, "R10 timeout flag", 32'(done_timeout), 32'd1);
      chk(nlog == 0, "R10 no writes after timeout", nlog, 0);
      chk(pre_reads == int'(tmo), "R10 status reads before abort", pre_reads, 32'(tmo));
    end else begin
      logic [7:0] dev;
      int bad;
      dev = 8'hE0 | {3'b000, drv, lba[27:24]};
      chk(pre_reads == pre + 1, "R2 status reads before first write", pre_reads, pre + 1);
      chk(log_a[0] == 10'h3F6 && log_d[0] == 0 && log_a[1] == 10'h1F2 && log_d[1] == 1,
          "R3 control and count", {log_a[0], 6'h0, log_d[1][7:0], log_d[0][7:0]},
          {10'h3F6, 6'h0, 8'h01, 8'h00});
      chk(log_a[2] == 10'h1F3 && log_d[2] == 32'(lba[7:0]) && log_a[3] == 10'h1F4 &&
          log_d[3] == 32'(lba[15:8]) && log_a[4] == 10'h1F5 && log_d[4] == 32'(lba[23:16]),
          "R3 lba bytes", {log_d[4][7:0], log_d[3][7:0], log_d[2][7:0]}, 32'(lba[23:0]));
      chk(log_a[5] == 10'h1F6 && log_d[5] == 32'(dev), "R4 device byte", log_d[5], 32'(dev));
      chk(log_a[6] == 10'h1F7 && log_d[6] == (wr ? 32'h30 : 32'h20), "R5 opcode",
          log_d[6], wr ? 32'h30 : 32'h20);
      if (wr) begin
        bad = 0;
        for (int k = 0; k < 128; k++)
          if (log_a[7 + k] != 10'h1F0 || log_d[7 + k] != wbuf[k]) bad++;
        chk(bad == 0 && nlog == 135, "R6 data words in order", nlog, 135);
      end else begin
        chk(nlog == 7, "R7 no writes on read", nlog, 7);
        if (!inj) begin
          bad = 0;
          for (int k = 0; k < 128; k++) if (rbuf[k] != rdw(lba, k)) bad++;
          chk(bad == 0 && nwe == 128, "R7 read words stored", nwe, 128);
        end else chk(nwe == 0, "R7 no data on error", nwe, 0);
      end
      chk(done_err == inj && done_code == (inj ? code : 8'h00) && !done_timeout,
          "R8 completion status", {done_timeout, done_err, done_code},
          {1'b0, inj, inj ? code : 8'h00});
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", 32'(done), 0);
  endtask

  initial begin
    logic [27:0] lbas [3];
    lbas[0] = 28'h0000000; lbas[1] = 28'hA1B2C3D; lbas[2] = 28'hFFFFFFF;
    rst_n = 0; tmo = 16'd1000; req_valid = 0; req_write = 0; req_drive = 0; req_lba = '0;
    cfg_pre = 0; cfg_mid = 0; cfg_inj = 0; cfg_code = 0; cfg_lba = '0; load = 1; clr = 1;
    for (int k = 0; k < 128; k++) wbuf[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    load = 0; clr = 0;
    // R1
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(!io_rd && !io_wr, "R1 bus idle after reset", {io_rd, io_wr}, 0);
    repeat (4) @(negedge clk);
    chk(done == 0 && nlog == 0, "R1 no activity without request", nlog, 0);

    // sweep: direction x drive x lba x error injection
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int l = 0; l < 3; l++)
          for (int e = 0; e < 2; e++)
            run_req(w[0], d[0], lbas[l], l + d, 1 + l, e[0], 8'h01 << (l + 2 * d + e), 1'b0);

    // R10 timeout on initial busy
    tmo = 16'd8;
    run_req(1'b1, 1'b0, 28'h0123456, 20, 0, 1'b0, 8'h00, 1'b1);
    tmo = 16'd1000;
    run_req(1'b0, 1'b1, 28'h7654321, 2, 2, 1'b0, 8'h00, 1'b0);

    // R9 queue full and order
    @(negedge clk);
    cfg_pre = 0; cfg_mid = 1; cfg_inj = 0; load = 1; clr = 1;
    @(negedge clk);
    load = 0; clr = 0;
    req_valid = 1; req_write = 1; req_drive = 0; req_lba = 28'h10;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    for (int i = 1; i < 5; i++) begin
      chk(req_ready == 1'b1, "R9 space while filling", 32'(req_ready), 1);
      req_valid = 1; req_lba = 28'h10 + 28'(i);
      @(negedge clk);
    end
    req_valid = 0;
    chk(req_ready == 1'b0, "R9 ready low when full", 32'(req_ready), 0);
    for (int i = 0; i < 5; i++) begin
      wait_done();
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++)
      chk(qlba[i] == 8'(8'h10 + i), "R9 service order", 32'(qlba[i]), 32'(8'h10 + i));
    chk(qn == 5, "R9 all queued served", qn, 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule